// File: doc/BRIEF.md
# Condition Result Forwarding Unit

This block sits between decode and execute. It decides where the condition-register operand of the next instruction comes from, and whether that instruction may enter execute. An instruction whose condition result is computed in the execute stage can hand that result straight to the instruction that follows it. A compare followed by a conditional branch therefore issues back to back, with no idle cycle between them.

Other condition writers produce their value only at writeback. These are the record-form instructions, multiplies, and writers that decode does not flag as execute-computed. The block counts these in-flight writers. A reader of the condition register is held in decode until every one of them has reported writeback. When nothing ahead is writing the condition register, the operand is the architected copy.

A flush drops the execute slot and the outstanding-writer count. Decode flags, the execute-stage condition value and the architected copy are inputs. The operand and a stall are the outputs.

Top module: `cond_fwd_unit`

## Requirements
- R1: When the instruction that issued in the previous cycle wrote the condition register with the execute-computed flag set, and it is neither record-form nor a multiply, then `cond_opnd_o` equals `ex_cond_i`, provided no writeback-only writer is outstanding and no flush is present. A reader then issues without stall.
- R2: A record-form writer (`dec_record_i`=1) is never forwarded. While it is outstanding, a valid reader sees `stall_o`=1 and `cond_opnd_o` equals `arch_cond_i`.
- R3: A multiply (`dec_mul_i`=1) is treated as a writeback-only writer even if its execute-computed flag is set.
- R4: When the execute slot holds no forwardable writer, `cond_opnd_o` equals `arch_cond_i`. This covers an empty slot and a slot holding a non-writer.
- R5: A forward replaces all 32 bits of the operand.
- R6: While `flush_i`=1, `stall_o`=0 and `cond_opnd_o` equals `arch_cond_i`. After a flush, the execute slot is empty and no writer is outstanding.
- R7: With `dec_valid_i`=0, no flag on the decode inputs is recorded, and `stall_o`=0.
- R8: At most MAX_PEND writeback-only writers may be outstanding. With MAX_PEND outstanding, another such writer sees `stall_o`=1.
- R9: Each `wb_done_i` pulse retires one outstanding writer. When the last one retires, the stall falls in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Pipeline flush; cancels forward and stall state |
| dec_valid_i | input | 1 | Decode holds an instruction |
| dec_rd_cond_i | input | 1 | Instruction reads the condition register |
| dec_wr_cond_i | input | 1 | Instruction writes the condition register |
| dec_ex_cond_i | input | 1 | Condition result is computed in execute |
| dec_record_i | input | 1 | Record-form variant (result at writeback) |
| dec_mul_i | input | 1 | Multiply operation |
| wb_done_i | input | 1 | One writeback-only condition writer has completed |
| ex_cond_i | input | 32 | Condition value computed in execute this cycle |
| arch_cond_i | input | 32 | Architected condition register copy |
| cond_opnd_o | output | 32 | Condition operand for the instruction in decode |
| stall_o | output | 1 | Hold the instruction in decode |

## Verification
A wrong execute-slot entry shows in the very next cycle. The operand switches between the execute value and the architected value, so distinct per-cycle values on the two data inputs expose it at once. A wrong outstanding count shows as a stall that never releases, or one that releases a cycle early relative to `wb_done_i`. It also shows as a missing stall when the limit is reached. All of these are visible on `stall_o` within one or two cycles of the mistake.

// File: rtl/cfwd_pkg.sv
package cfwd_pkg;

  typedef struct packed {
    logic valid;
    logic wr;
    logic fwd_ok;
  } ex_slot_t;

  // condition value is available at the end of execute and may bypass
  function automatic logic fwd_eligible(logic wr, logic in_ex, logic rec, logic mul);
    return wr & in_ex & ~rec & ~mul;
  endfunction

  // writer whose value only lands in the architected copy at writeback
  function automatic logic wb_only(logic wr, logic in_ex, logic rec, logic mul);
    return wr & ~fwd_eligible(wr, in_ex, rec, mul);
  endfunction

endpackage

// File: rtl/cfwd_track.sv
module cfwd_track
  import cfwd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  logic     issue,
  input  logic     wr,
  input  logic     fwd_ok,
  output ex_slot_t slot
);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      slot <= '0;
    end else if (issue) begin
      slot.valid  <= 1'b1;
      slot.wr     <= wr;
      slot.fwd_ok <= fwd_ok;
    end else begin
      slot <= '0;
    end
  end

  a_r7_idle_leaves_slot_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !slot.valid);

  a_r6_flush_empties_slot: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !slot.valid);

endmodule

// File: rtl/cfwd_pend.sv
module cfwd_pend #(
  parameter int MAX_PEND = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic inc,
  input  logic dec,
  output logic busy,
  output logic full
);

  localparam int CNT_W = $clog2(MAX_PEND + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PEND);

  logic [CNT_W-1:0] cnt;
  logic             retire;

  assign retire = dec && (cnt != '0);
  assign busy   = (cnt != '0);
  assign full   = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) cnt <= '0;
    else                 cnt <= cnt + CNT_W'(inc) - CNT_W'(retire);
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);

  a_r9_last_retire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && cnt == CNT_W'(1) && !inc) |=> !busy);

  a_r6_flush_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !busy);

endmodule

// File: rtl/cfwd_sel.sv
module cfwd_sel
  import cfwd_pkg::*;
#(
  parameter int W = 32
) (
  input  ex_slot_t       slot,
  input  logic           pend_busy,
  input  logic           flush,
  input  logic [W-1:0]   ex_val,
  input  logic [W-1:0]   arch_val,
  output logic           fwd_sel,
  output logic [W-1:0]   opnd
);

  assign fwd_sel = slot.valid & slot.wr & slot.fwd_ok & ~pend_busy & ~flush;
  assign opnd    = fwd_sel ? ex_val : arch_val;

endmodule

// File: rtl/cond_fwd_unit.sv
module cond_fwd_unit
  import cfwd_pkg::*;
#(
  parameter int W        = 32,
  parameter int MAX_PEND = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic         dec_valid_i,
  input  logic         dec_rd_cond_i,
  input  logic         dec_wr_cond_i,
  input  logic         dec_ex_cond_i,
  input  logic         dec_record_i,
  input  logic         dec_mul_i,
  input  logic         wb_done_i,
  input  logic [W-1:0] ex_cond_i,
  input  logic [W-1:0] arch_cond_i,
  output logic [W-1:0] cond_opnd_o,
  output logic         stall_o
);

  ex_slot_t slot;
  logic     dec_fwd_ok;
  logic     dec_wb_only;
  logic     pend_busy;
  logic     pend_full;
  logic     issue;
  logic     issue_fwd;
  logic     fwd_sel;

  assign dec_fwd_ok  = fwd_eligible(dec_wr_cond_i, dec_ex_cond_i, dec_record_i, dec_mul_i);
  assign dec_wb_only = wb_only(dec_wr_cond_i, dec_ex_cond_i, dec_record_i, dec_mul_i);

  assign stall_o   = ~flush_i & dec_valid_i &
                     ((dec_rd_cond_i & pend_busy) | (dec_wb_only & pend_full));
  assign issue     = dec_valid_i & ~stall_o & ~flush_i;
  assign issue_fwd = issue & dec_fwd_ok;

  cfwd_track u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush_i),
    .issue  (issue),
    .wr     (dec_wr_cond_i),
    .fwd_ok (dec_fwd_ok),
    .slot   (slot)
  );

  cfwd_pend #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush_i),
    .inc   (issue & dec_wb_only),
    .dec   (wb_done_i),
    .busy  (pend_busy),
    .full  (pend_full)
  );

  cfwd_sel #(.W(W)) u_sel (
    .slot      (slot),
    .pend_busy (pend_busy),
    .flush     (flush_i),
    .ex_val    (ex_cond_i),
    .arch_val  (arch_cond_i),
    .fwd_sel   (fwd_sel),
    .opnd      (cond_opnd_o)
  );

  a_r1_forward_next: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(issue_fwd) && !pend_busy && !flush_i) |-> cond_opnd_o == ex_cond_i);

  a_r2_no_fwd_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend_busy |-> cond_opnd_o == arch_cond_i);

  a_r3_mul_never_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_mul_i) |=> !fwd_sel);

  a_r6_flush_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> (!stall_o && cond_opnd_o == arch_cond_i));

  a_r7_invalid_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |-> !stall_o);

endmodule

// File: tb/sim_cond_fwd_unit.sv
module sim_cond_fwd_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0, dec_valid_i = 1'b0, dec_rd_cond_i = 1'b0, dec_wr_cond_i = 1'b0;
  logic        dec_ex_cond_i = 1'b0, dec_record_i = 1'b0, dec_mul_i = 1'b0, wb_done_i = 1'b0;
  logic [31:0] ex_cond_i = '0, arch_cond_i = '0;
  logic [31:0] cond_opnd_o;
  logic        stall_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  cond_fwd_unit #(.W(32), .MAX_PEND(2)) u0 (.*);

  // {valid, rd, wr, in_ex, record, mul, wb_done, flush, exp_fwd, exp_stall}
  localparam int NV = 26;
  localparam logic [9:0] VEC [NV] = '{
    10'b1_0_1_1_0_0_0_0_0_0, // 0  compare issues
    10'b1_1_0_0_0_0_0_0_1_0, // 1  R1 branch takes forwarded value
    10'b1_1_0_0_0_0_0_0_0_0, // 2  R4 slot holds non-writer
    10'b1_0_1_1_1_0_0_0_0_0, // 3  record-form writer
    10'b1_1_0_0_0_0_0_0_0_1, // 4  R2 reader stalls
    10'b1_1_0_0_0_0_1_0_0_1, // 5  R9 writeback arrives, still held
    10'b1_1_0_0_0_0_0_0_0_0, // 6  R9 released
    10'b1_0_1_1_0_1_0_0_0_0, // 7  multiply with exec flag
    10'b1_1_0_0_0_0_1_0_0_1, // 8  R3 reader stalls
    10'b1_1_0_0_0_0_0_0_0_0, // 9  released
    10'b1_0_1_1_0_0_0_0_0_0, // 10 forwardable writer
    10'b1_1_0_0_0_0_0_1_0_0, // 11 R6 flush cancels forward
    10'b1_1_0_0_0_0_0_0_0_0, // 12 R6 slot empty
    10'b1_0_1_0_0_0_0_0_0_0, // 13 writer not flagged for execute
    10'b0_0_0_0_0_0_0_0_0_0, // 14 idle
    10'b1_1_0_0_0_0_0_1_0_0, // 15 R6 flush drops pending stall
    10'b1_1_0_0_0_0_0_0_0_0, // 16 R6 count cleared
    10'b0_1_1_1_0_0_0_0_0_0, // 17 R7 invalid decode
    10'b1_1_0_0_0_0_0_0_0_0, // 18 R7 nothing recorded
    10'b1_0_1_1_1_0_0_0_0_0, // 19 record writer 1
    10'b1_0_1_1_1_0_0_0_0_0, // 20 record writer 2
    10'b1_0_1_1_1_0_0_0_0_1, // 21 R8 limit reached
    10'b1_0_1_1_0_0_0_0_0_0, // 22 forwardable writer passes
    10'b1_1_0_0_0_0_1_0_0_1, // 23 R2 pending blocks reader
    10'b1_1_0_0_0_0_1_0_0_1, // 24 R9 one still outstanding
    10'b1_1_0_0_0_0_0_0_0_0  // 25 R9 released
  };

  function automatic string req_of(int i);
    case (i)
      1: return "R1";
      2: return "R4";
      4, 23: return "R2";
      5, 6, 24, 25: return "R9";
      8, 9: return "R3";
      11, 12, 15, 16: return "R6";
      17, 18: return "R7";
      21: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] exp_op, logic exp_st);
    n_chk++;
    if (cond_opnd_o !== exp_op || stall_o !== exp_st) begin
      n_bad++;
      $display("FAIL %s: opnd=%h stall=%b expected opnd=%h stall=%b",
               req, cond_opnd_o, stall_o, exp_op, exp_st);
    end
  endtask

  task automatic drive(logic v, logic rd, logic wr, logic ie, logic rec, logic mul,
                       logic wbd, logic fl, logic [31:0] ex, logic [31:0] ar);
    dec_valid_i = v; dec_rd_cond_i = rd; dec_wr_cond_i = wr; dec_ex_cond_i = ie;
    dec_record_i = rec; dec_mul_i = mul; wb_done_i = wbd; flush_i = fl;
    ex_cond_i = ex; arch_cond_i = ar;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state: reader sees architected copy, no stall
    drive(1, 1, 0, 0, 0, 0, 0, 0, 32'h1111_1111, 32'h2222_2222);
    #1 check("R4", 32'h2222_2222, 1'b0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [9:0] r;
      logic [31:0] exv, arv;
      r   = VEC[i];
      exv = 32'hE000_0000 | 32'(i);
      arv = 32'hA000_0000 | 32'(i);
      drive(r[9], r[8], r[7], r[6], r[5], r[4], r[3], r[2], exv, arv);
      #1 check(req_of(i), r[1] ? exv : arv, r[0]);
      @(negedge clk);
    end

    // R5: full-width replacement in both directions
    drive(1, 0, 1, 1, 0, 0, 0, 0, 32'h0, 32'h0);
    @(negedge clk);
    drive(1, 1, 1, 1, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h0000_0000);
    #1 check("R5", 32'hFFFF_FFFF, 1'b0);
    @(negedge clk);
    drive(1, 1, 0, 0, 0, 0, 0, 0, 32'h0000_0000, 32'hFFFF_FFFF);
    #1 check("R5", 32'h0000_0000, 1'b0);
    @(negedge clk);
    drive(1, 1, 0, 0, 0, 0, 0, 0, 32'h8000_0001, 32'h7FFF_FFFE);
    #1 check("R4", 32'h7FFF_FFFE, 1'b0);
    @(negedge clk);

    // reset with a writer outstanding clears the stall
    drive(1, 0, 1, 0, 0, 1, 0, 0, 32'h0, 32'h0);
    @(negedge clk);
    drive(1, 1, 0, 0, 0, 0, 0, 0, 32'h3, 32'h4);
    #1 check("R3", 32'h4, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R4", 32'h4, 1'b0);
    @(negedge clk);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule